// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the command pins of one 16-bit SDR SDRAM device that has four banks, 13 row address bits and 9 column address bits. Once reset is released it brings the device up in a fixed order. First it raises the clock enable and holds NOP for a programmable settling time. It then closes every bank with a precharge-all, issues a run of tightly spaced auto-refresh cycles, and writes the mode register. After that it enters normal operation.

In normal operation the block raises `ready` and keeps it high. It counts the cycles since the last refresh. When a refresh falls due it raises a request and waits for an external grant. Only after the grant does it close all banks and issue the auto-refresh. Between these commands it drives NOP. Data transfers, self-refresh and any host bus are handled elsewhere. This block only enforces the minimum spacing between the commands it issues itself.

Top module: `sdr_pwrup_refresh_seq`

## Requirements
- R1: While reset is asserted, `sd_cke`, `ready` and `rfsh_req` are low and the pins carry NOP. `sd_cke` rises on the first clock edge after reset is released. The first non-NOP command is a precharge-all (`sd_addr` = 1 << 10, `sd_ba` = 0). It appears exactly `PWRUP_WAIT` cycles after the first cycle with `sd_cke` high, and every cycle before it carries NOP.
- R2: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows: NOP = 0111, precharge = 0010, auto-refresh = 0001, load-mode = 0000. No other code ever appears. NOP and auto-refresh drive `sd_addr` = 0 and `sd_ba` = 0.
- R3: The first of exactly `INIT_REF_CNT` (8) auto-refresh commands comes `T_RP` (3) cycles after the initial precharge-all. The rest follow at a spacing of exactly `INIT_RFSH_GAP` (32) cycles.
- R4: No command follows a precharge within fewer than `T_RP` (3) cycles.
- R5: No command follows an auto-refresh within fewer than `T_RFC` (6) cycles. The mode load comes exactly `T_RFC` cycles after the last initial auto-refresh.
- R6: The mode load drives `sd_ba` = 0 and `sd_addr` = 0x033. In that word, bits [2:0] = 3 select a burst of 8, bit 3 = 0 selects sequential order, bits [6:4] = 3 select CAS latency 3, and bits [8:7] = 0 select standard operation. All other bits are zero.
- R7: `ready` is low until exactly `T_MRD` (3) cycles after the mode load. From that cycle on it stays high.
- R8: In normal mode, `rfsh_req` first reads high `RUN_RFSH_GAP - T_RP - 1` (444) cycles after the mode load or the previous auto-refresh. It stays high until a grant is sampled.
- R9: When `rfsh_req` and `rfsh_gnt` are both high at a clock edge, a precharge-all appears in the next cycle and `rfsh_req` drops in that same cycle. An auto-refresh follows `T_RP` cycles later. With an immediate grant, auto-refresh commands are exactly `RUN_RFSH_GAP` (448) cycles apart.
- R10: `rfsh_gnt` has no effect during initialisation or while no request is pending. No command appears and the timing does not move.
- R11: A grant that comes D cycles after the request delays the precharge-all and the auto-refresh by D cycles. The next refresh interval is measured from that delayed auto-refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rfsh_gnt | input | 1 | Permission to close banks and refresh |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Row/mode address bus |
| ready | output | 1 | Initialisation complete |
| rfsh_req | output | 1 | Refresh due, waiting for grant |

## Verification
Every command appears a fixed number of cycles after its cause. Counted from the first cycle with `sd_cke` high, the precharge-all lands `PWRUP_WAIT` cycles later. The init refreshes land at precharge + 3 + 32·i, the mode load lands 6 cycles after the last one, and `ready` rises 3 cycles after that. In normal mode, the request reads high 444 cycles after the last refresh, the precharge lands one cycle after the sampled grant, and the refresh lands 3 cycles after that. The bench computes each of these absolute cycle stamps before the run and queues them with the expected code, address and bank. A monitor samples the pins at the falling edge, stamps each non-NOP command with the cycle count and compares it with the head of the queue. Any early, late, extra or missing command is therefore caught at its exact cycle. The level checks on `ready` and `rfsh_req` are made in the cycles just before and just at each transition.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

   // Command code on {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_NOP = 4'b0111,
      CMD_PRE = 4'b0010,
      CMD_REF = 4'b0001,
      CMD_MRS = 4'b0000
   } sdr_cmd_e;

   typedef enum logic [3:0] {
      ST_RESET,
      ST_PWRUP,
      ST_IPRE,
      ST_IPRE_GAP,
      ST_IREF,
      ST_IREF_GAP,
      ST_MRS,
      ST_MRS_GAP,
      ST_IDLE,
      ST_REQ,
      ST_RPRE,
      ST_RPRE_GAP,
      ST_RREF,
      ST_RREF_GAP
   } seq_state_e;

   // Burst length field of the mode word
   function automatic logic [2:0] burst_code(input int unsigned blen);
      case (blen)
         1:       return 3'd0;
         2:       return 3'd1;
         4:       return 3'd2;
         8:       return 3'd3;
         default: return 3'd7;
      endcase
   endfunction

endpackage

// File: rtl/sdr_gap_timer.sv
// Down counter: loaded with (wait cycles - 1), reports zero when the wait is over.
module sdr_gap_timer #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdr_ivl_counter.sv
// Saturating up counter of cycles since the last refresh or mode load.
module sdr_ivl_counter #(
   parameter int unsigned W      = 10,
   parameter int unsigned HIT_AT = 444
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic hit
);

   localparam logic [W-1:0] HIT_V = W'(HIT_AT);
   localparam logic [W-1:0] SAT_V = '1;

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (cnt_q != SAT_V) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign hit = (cnt_q == HIT_V);

endmodule

// File: rtl/sdr_seq_fsm.sv
module sdr_seq_fsm
   import sdr_seq_pkg::*;
#(
   parameter int unsigned GAP_W         = 16,
   parameter int unsigned PWRUP_WAIT    = 20000,
   parameter int unsigned INIT_REF_CNT  = 8,
   parameter int unsigned INIT_RFSH_GAP = 32,
   parameter int unsigned T_RP          = 3,
   parameter int unsigned T_RFC         = 6,
   parameter int unsigned T_MRD         = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gap_zero,
   input  logic             ivl_hit,
   input  logic             rfsh_gnt,
   output seq_state_e       state,
   output logic             gap_load,
   output logic [GAP_W-1:0] gap_val,
   output logic             ivl_clr
);

   localparam int unsigned REFC_W = $clog2(INIT_REF_CNT + 1);

   // Timer load values: a gap of N cycles between commands waits N-1 cycles.
   localparam logic [GAP_W-1:0] LD_PWRUP = GAP_W'(PWRUP_WAIT - 1);
   localparam logic [GAP_W-1:0] LD_RP    = GAP_W'(T_RP - 2);
   localparam logic [GAP_W-1:0] LD_RFC   = GAP_W'(T_RFC - 2);
   localparam logic [GAP_W-1:0] LD_MRD   = GAP_W'(T_MRD - 2);
   localparam logic [GAP_W-1:0] LD_IREF  = GAP_W'(INIT_RFSH_GAP - 2);
   localparam logic [REFC_W-1:0] REF_LAST = REFC_W'(INIT_REF_CNT - 1);
   localparam logic [REFC_W-1:0] REF_DONE = REFC_W'(INIT_REF_CNT);

   seq_state_e        state_q, state_d;
   logic [REFC_W-1:0] iref_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RESET;
         iref_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IREF) begin
            iref_q <= iref_q + 1'b1;
         end
      end
   end

   always_comb begin
      state_d  = state_q;
      gap_load = 1'b0;
      gap_val  = '0;
      unique case (state_q)
         ST_RESET: begin
            state_d  = ST_PWRUP;
            gap_load = 1'b1;
            gap_val  = LD_PWRUP;
         end
         ST_PWRUP:    if (gap_zero) state_d = ST_IPRE;
         ST_IPRE: begin
            state_d  = ST_IPRE_GAP;
            gap_load = 1'b1;
            gap_val  = LD_RP;
         end
         ST_IPRE_GAP: if (gap_zero) state_d = ST_IREF;
         ST_IREF: begin
            state_d  = ST_IREF_GAP;
            gap_load = 1'b1;
            gap_val  = (iref_q == REF_LAST) ? LD_RFC : LD_IREF;
         end
         ST_IREF_GAP: begin
            if (gap_zero) begin
               state_d = (iref_q == REF_DONE) ? ST_MRS : ST_IREF;
            end
         end
         ST_MRS: begin
            state_d  = ST_MRS_GAP;
            gap_load = 1'b1;
            gap_val  = LD_MRD;
         end
         ST_MRS_GAP:  if (gap_zero) state_d = ST_IDLE;
         ST_IDLE:     if (ivl_hit) state_d = ST_REQ;
         ST_REQ:      if (rfsh_gnt) state_d = ST_RPRE;
         ST_RPRE: begin
            state_d  = ST_RPRE_GAP;
            gap_load = 1'b1;
            gap_val  = LD_RP;
         end
         ST_RPRE_GAP: if (gap_zero) state_d = ST_RREF;
         ST_RREF: begin
            state_d  = ST_RREF_GAP;
            gap_load = 1'b1;
            gap_val  = LD_RFC;
         end
         ST_RREF_GAP: if (gap_zero) state_d = ST_IDLE;
         default:     state_d = ST_RESET;
      endcase
   end

   assign state   = state_q;
   assign ivl_clr = (state_q == ST_IREF) || (state_q == ST_MRS) || (state_q == ST_RREF);

endmodule

// File: rtl/sdr_cmd_drive.sv
module sdr_cmd_drive
   import sdr_seq_pkg::*;
#(
   parameter int unsigned ROW_W     = 13,
   parameter int unsigned BANK_W    = 2,
   parameter int unsigned AP_BIT    = 10,
   parameter int unsigned BURST_LEN = 8,
   parameter int unsigned CAS_LAT   = 3
) (
   input  seq_state_e        state,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BANK_W-1:0] ba,
   output logic [ROW_W-1:0]  addr,
   output logic              ready,
   output logic              rfsh_req
);

   // Mode word: op mode [8:7]=0, CAS latency [6:4], sequential [3]=0, burst [2:0]
   localparam logic [8:0] MODE_LOW =
      {2'b00, 3'(CAS_LAT), 1'b0, burst_code(BURST_LEN)};
   localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(MODE_LOW);

   logic [ROW_W-1:0] pre_all_addr;
   sdr_cmd_e         cmd;

   for (genvar i = 0; i < ROW_W; i++) begin : g_ap
      assign pre_all_addr[i] = (i == AP_BIT);
   end

   always_comb begin
      cmd  = CMD_NOP;
      addr = '0;
      unique case (state)
         ST_IPRE, ST_RPRE: begin
            cmd  = CMD_PRE;
            addr = pre_all_addr;
         end
         ST_IREF, ST_RREF: cmd = CMD_REF;
         ST_MRS: begin
            cmd  = CMD_MRS;
            addr = MODE_WORD;
         end
         default: cmd = CMD_NOP;
      endcase
   end

   assign {cs_n, ras_n, cas_n, we_n} = cmd;
   assign ba       = '0;
   assign cke      = (state != ST_RESET);
   assign rfsh_req = (state == ST_REQ);
   assign ready    = (state == ST_IDLE) || (state == ST_REQ) ||
                     (state == ST_RPRE) || (state == ST_RPRE_GAP) ||
                     (state == ST_RREF) || (state == ST_RREF_GAP);

endmodule

// File: rtl/sdr_pwrup_refresh_seq.sv
module sdr_pwrup_refresh_seq
   import sdr_seq_pkg::*;
#(
   parameter int unsigned ROW_W         = 13,
   parameter int unsigned COL_W         = 9,
   parameter int unsigned BANK_W        = 2,
   parameter int unsigned DATA_W        = 16,
   parameter int unsigned AP_BIT        = 10,
   parameter int unsigned PWRUP_WAIT    = 20000,
   parameter int unsigned INIT_REF_CNT  = 8,
   parameter int unsigned INIT_RFSH_GAP = 32,
   parameter int unsigned RUN_RFSH_GAP  = 448,
   parameter int unsigned T_RP          = 3,
   parameter int unsigned T_RFC         = 6,
   parameter int unsigned T_MRD         = 3,
   parameter int unsigned BURST_LEN     = 8,
   parameter int unsigned CAS_LAT       = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rfsh_gnt,
   output logic              sd_cke,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [BANK_W-1:0] sd_ba,
   output logic [ROW_W-1:0]  sd_addr,
   output logic              ready,
   output logic              rfsh_req
);

   localparam int unsigned MAX_WAIT =
      (PWRUP_WAIT > INIT_RFSH_GAP) ? PWRUP_WAIT : INIT_RFSH_GAP;
   localparam int unsigned GAP_W  = $clog2(MAX_WAIT + 1) + 1;
   localparam int unsigned IVL_W  = $clog2(RUN_RFSH_GAP + 1) + 1;
   localparam int unsigned REQ_AT = RUN_RFSH_GAP - T_RP - 3;

   // Elaboration-time parameter checks
   if (BANK_W != 2 || ROW_W != 13 || COL_W != 9 || DATA_W != 16) begin : g_bad_geom
      $error("sdr_pwrup_refresh_seq: geometry must be 4 banks, 13 rows, 9 cols, x16");
   end
   if (AP_BIT >= ROW_W) begin : g_bad_ap
      $error("sdr_pwrup_refresh_seq: AP_BIT outside address bus");
   end
   if (T_RP < 2 || T_RFC < 2 || T_MRD < 2 || PWRUP_WAIT < 2) begin : g_bad_gap
      $error("sdr_pwrup_refresh_seq: every timing gap must be at least 2 cycles");
   end
   if (INIT_REF_CNT < 1 || INIT_RFSH_GAP < T_RFC) begin : g_bad_init
      $error("sdr_pwrup_refresh_seq: init refresh count or spacing illegal");
   end
   if (RUN_RFSH_GAP < T_RP + T_RFC + T_MRD + 4) begin : g_bad_run
      $error("sdr_pwrup_refresh_seq: run refresh interval too short");
   end
   if (CAS_LAT < 1 || CAS_LAT > 3) begin : g_bad_cl
      $error("sdr_pwrup_refresh_seq: CAS latency must be 1..3");
   end

   seq_state_e       state;
   logic             gap_load, gap_zero, ivl_clr, ivl_hit;
   logic [GAP_W-1:0] gap_val;

   sdr_seq_fsm #(
      .GAP_W         (GAP_W),
      .PWRUP_WAIT    (PWRUP_WAIT),
      .INIT_REF_CNT  (INIT_REF_CNT),
      .INIT_RFSH_GAP (INIT_RFSH_GAP),
      .T_RP          (T_RP),
      .T_RFC         (T_RFC),
      .T_MRD         (T_MRD)
   ) fsm_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .gap_zero (gap_zero),
      .ivl_hit  (ivl_hit),
      .rfsh_gnt (rfsh_gnt),
      .state    (state),
      .gap_load (gap_load),
      .gap_val  (gap_val),
      .ivl_clr  (ivl_clr)
   );

   sdr_gap_timer #(.W(GAP_W)) gap_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (gap_load),
      .load_val (gap_val),
      .zero     (gap_zero)
   );

   sdr_ivl_counter #(.W(IVL_W), .HIT_AT(REQ_AT)) ivl_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ivl_clr),
      .hit   (ivl_hit)
   );

   sdr_cmd_drive #(
      .ROW_W     (ROW_W),
      .BANK_W    (BANK_W),
      .AP_BIT    (AP_BIT),
      .BURST_LEN (BURST_LEN),
      .CAS_LAT   (CAS_LAT)
   ) drv_i (
      .state    (state),
      .cke      (sd_cke),
      .cs_n     (sd_cs_n),
      .ras_n    (sd_ras_n),
      .cas_n    (sd_cas_n),
      .we_n     (sd_we_n),
      .ba       (sd_ba),
      .addr     (sd_addr),
      .ready    (ready),
      .rfsh_req (rfsh_req)
   );

endmodule

// File: rtl/sdr_seq_checker.sv
module sdr_seq_checker #(
   parameter int unsigned ROW_W  = 13,
   parameter int unsigned BANK_W = 2,
   parameter int unsigned T_RP   = 3,
   parameter int unsigned T_RFC  = 6,
   parameter int unsigned T_MRD  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rfsh_gnt,
   input logic              sd_cke,
   input logic              sd_cs_n,
   input logic              sd_ras_n,
   input logic              sd_cas_n,
   input logic              sd_we_n,
   input logic [BANK_W-1:0] sd_ba,
   input logic [ROW_W-1:0]  sd_addr,
   input logic              ready,
   input logic              rfsh_req
);

   localparam logic [3:0] C_NOP = 4'b0111;
   localparam logic [3:0] C_PRE = 4'b0010;
   localparam logic [3:0] C_REF = 4'b0001;
   localparam logic [3:0] C_MRS = 4'b0000;
   localparam logic [ROW_W-1:0] MODE_EXP = ROW_W'(9'h033);

   logic [3:0] cmd;
   logic [3:0] last_q;
   logic [7:0] since_q;
   logic       seen_mrs_q;

   assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q     <= C_NOP;
         since_q    <= '0;
         seen_mrs_q <= 1'b0;
      end else begin
         if (cmd != C_NOP) begin
            last_q  <= cmd;
            since_q <= 8'd1;
         end else if (since_q != 8'hFF) begin
            since_q <= since_q + 1'b1;
         end
         if (cmd == C_MRS) seen_mrs_q <= 1'b1;
      end
   end

   p_nop_cke_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !sd_cke |-> (cmd == C_NOP));

   p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == C_NOP) || (cmd == C_PRE) || (cmd == C_REF) || (cmd == C_MRS));

   p_pre_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != C_NOP && last_q == C_PRE) |-> (since_q >= 8'(T_RP)));

   p_ref_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != C_NOP && last_q == C_REF) |-> (since_q >= 8'(T_RFC)));

   p_mrs_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != C_NOP && last_q == C_MRS) |-> (since_q >= 8'(T_MRD)));

   p_mode_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == C_MRS) |-> (sd_addr == MODE_EXP && sd_ba == '0));

   p_ready_after_mrs_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> seen_mrs_q);

   p_ready_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);

   p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rfsh_req && !rfsh_gnt) |=> rfsh_req);

   p_pre_needs_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && cmd == C_PRE) |-> $past(rfsh_req && rfsh_gnt));

endmodule

bind sdr_pwrup_refresh_seq sdr_seq_checker #(
   .ROW_W  (ROW_W),
   .BANK_W (BANK_W),
   .T_RP   (T_RP),
   .T_RFC  (T_RFC),
   .T_MRD  (T_MRD)
) chk_i (.*);

// File: tb/sdr_pwrup_refresh_seq_tb_top.sv
`timescale 1ns/1ps
module sdr_pwrup_refresh_seq_tb_top;

   localparam int PW       = 10;
   localparam int RST_AT   = 5;
   localparam int N_RUN    = 5;
   localparam logic [3:0] E_NOP = 4'b0111;
   localparam logic [3:0] E_PRE = 4'b0010;
   localparam logic [3:0] E_REF = 4'b0001;
   localparam logic [3:0] E_MRS = 4'b0000;
   localparam logic [12:0] A_PRE  = 13'h0400;
   localparam logic [12:0] A_MODE = 13'h0033;

   logic clk = 1'b0;
   logic rst_n;
   logic gnt;
   logic cke, cs_n, ras_n, cas_n, we_n, ready, req;
   logic [1:0]  ba;
   logic [12:0] addr;

   int cyc = 0;
   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic [3:0]  code;
      int          at;
      logic [12:0] addr;
      string       tag;
   } exp_t;
   exp_t sb_q[$];

   always #2 clk = ~clk;   // 250 MHz
   always @(posedge clk) cyc <= cyc + 1;

   sdr_pwrup_refresh_seq #(.PWRUP_WAIT(PW)) dut_i (
      .clk(clk), .rst_n(rst_n), .rfsh_gnt(gnt),
      .sd_cke(cke), .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n),
      .sd_we_n(we_n), .sd_ba(ba), .sd_addr(addr),
      .ready(ready), .rfsh_req(req)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   task automatic push(input logic [3:0] code, input int at,
                       input logic [12:0] a, input string tag);
      exp_t e;
      e.code = code; e.at = at; e.addr = a; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic wait_cyc(input int n);
      do @(negedge clk); while (cyc != n);
   endtask

   // Monitor: stamps every non-NOP command and compares with the queue head
   always @(negedge clk) begin
      if (rst_n === 1'b1 && !done) begin
         logic [3:0] code;
         code = {cs_n, ras_n, cas_n, we_n};
         if (code != E_NOP) begin
            check(code == E_PRE || code == E_REF || code == E_MRS, "R2",
                  "illegal command code", int'(code), int'(E_NOP));
            check(cke == 1'b1, "R1", "command while cke low", int'(cke), 1);
            if (sb_q.size() == 0) begin
               check(1'b0, "R10", "unexpected command", int'(code), int'(E_NOP));
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               check(code == e.code, e.tag, "command code", int'(code), int'(e.code));
               check(cyc == e.at, e.tag, "command cycle", cyc, e.at);
               check(addr == e.addr, e.tag, "address", int'(addr), int'(e.addr));
               check(ba == 2'b00, e.tag, "bank", int'(ba), 0);
            end
         end else begin
            if (addr != 13'h0 || ba != 2'b00)
               check(1'b0, "R2", "NOP address not zero", int'(addr), 0);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "WDOG", "watchdog expired", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int c_k, pre0, mrs, r, q, pre;
      int dly[N_RUN] = '{0, 0, 5, 17, 0};
      rst_n = 1'b0;
      gnt   = 1'b1;   // held through init: must be ignored (R10)

      // Expected schedule from the requirements
      c_k  = RST_AT + 1;
      pre0 = c_k + PW;
      push(E_PRE, pre0, A_PRE, "R1");
      for (int i = 0; i < 8; i++) push(E_REF, pre0 + 3 + 32 * i, 13'h0, "R3");
      mrs = pre0 + 3 + 7 * 32 + 6;
      push(E_MRS, mrs, A_MODE, "R5/R6");
      r = mrs;
      for (int k = 0; k < N_RUN; k++) begin
         q   = r + 444;
         pre = q + dly[k] + 1;
         push(E_PRE, pre, A_PRE, (dly[k] != 0) ? "R11" : "R9");
         push(E_REF, pre + 3, 13'h0, (dly[k] != 0) ? "R11" : "R9");
         r = pre + 3;
      end

      // Reset state (R1)
      wait_cyc(3);
      check(cke == 1'b0, "R1", "cke in reset", int'(cke), 0);
      check({cs_n, ras_n, cas_n, we_n} == E_NOP, "R1", "cmd in reset",
            int'({cs_n, ras_n, cas_n, we_n}), int'(E_NOP));
      check(ready == 1'b0, "R1", "ready in reset", int'(ready), 0);
      check(req == 1'b0, "R1", "req in reset", int'(req), 0);
      wait_cyc(RST_AT);
      rst_n = 1'b1;
      check(cke == 1'b0, "R1", "cke before first edge", int'(cke), 0);
      wait_cyc(c_k);
      check(cke == 1'b1, "R1", "cke after first edge", int'(cke), 1);

      // Ready timing (R7)
      wait_cyc(mrs + 2);
      check(ready == 1'b0, "R7", "ready before T_MRD", int'(ready), 0);
      wait_cyc(mrs + 3);
      check(ready == 1'b1, "R7", "ready at T_MRD", int'(ready), 1);
      gnt = 1'b0;

      r = mrs;
      for (int k = 0; k < N_RUN; k++) begin
         q   = r + 444;
         pre = q + dly[k] + 1;
         if (k == 1) begin
            wait_cyc(r + 10);
            gnt = 1'b1;           // held high while idle (R10)
         end
         if (k == 3) begin
            wait_cyc(q - 100);
            gnt = 1'b1;           // stray grant, no request (R10)
            wait_cyc(q - 97);
            gnt = 1'b0;
         end
         wait_cyc(q - 1);
         check(req == 1'b0, "R8", "req before due", int'(req), 0);
         wait_cyc(q);
         check(req == 1'b1, "R8", "req when due", int'(req), 1);
         if (dly[k] != 0) begin
            wait_cyc(q + dly[k]);
            check(req == 1'b1, "R8", "req held without grant", int'(req), 1);
         end
         gnt = 1'b1;
         wait_cyc(pre);
         gnt = 1'b0;
         check(req == 1'b0, "R9", "req drops with precharge", int'(req), 0);
         wait_cyc(pre + 3);
         check(ready == 1'b1, "R7", "ready stays high", int'(ready), 1);
         r = pre + 3;
      end

      wait_cyc(r + 20);
      check(sb_q.size() == 0, "R9", "commands still expected", sb_q.size(), 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule